// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

This block gathers up to 32 peripheral interrupt lines into a single request for a processor. Each line is fixed at build time as edge or level sensitive. A captured event stays in a status register until software clears it with a write-one-to-clear acknowledge. An enable register masks status into a pending view. A priority encoder names the lowest-numbered pending line through a vector register. A two-bit master control decides whether inputs are captured and whether the request pin is driven.

Software reaches everything through a simple synchronous 32-bit register port with a byte address, a write strobe, write data and registered read data. An interrupt handler can read the vector register over and over, servicing and acknowledging each line, until the register reads all ones. Enable bits can be changed one at a time through separate set and clear aliases, so no read-modify-write is needed.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the enable, status and master control registers read zero, `irq_o` is low and the vector register reads 0xFFFFFFFF.
- R2: A write to byte offset 0x08 replaces all 32 enable bits, and a read of 0x08 returns them. Read data appears on `rdata_o` one cycle after the address is presented.
- R3: Writing a mask to offset 0x10 ORs it into the enable register. Writing a mask to offset 0x14 clears exactly those enable bits. All other enable bits keep their values.
- R4: A line whose bit in `EDGE_MASK` is 1 sets its status bit (offset 0x00) only on a 0-to-1 transition. The bit stays set after the line falls. A line held high does not set it again after an acknowledge.
- R5: A line whose bit in `EDGE_MASK` is 0 sets its status bit in every cycle it is high. An acknowledge while the line is still high leaves the bit set. An acknowledge after the line has dropped clears it.
- R6: Writing to offset 0x0C clears the status bits written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF clears all status bits.
- R7: Offset 0x04 reads status AND enable.
- R8: Offset 0x18 reads the index of the lowest-numbered pending line, zero-extended, or 0xFFFFFFFF when nothing is pending.
- R9: Master control is at offset 0x1C. Bit 0 enables the output and bit 1 enables hardware capture. `irq_o` is high only when some line is pending and both bits are set.
- R10: While master bit 1 is clear, input activity sets no status bit.
- R11: Lines with an index at or above `NUM_ACTIVE` never set a status bit, whatever they are driven to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral interrupt lines, synchronous to clk_i |
| addr_i | input | 5 | Byte address of the register, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with `NUM_ACTIVE` = 6 and `EDGE_MASK` = 0x0000000A, so lines 1 and 3 are edge sensitive and lines 0, 2, 4 and 5 are level sensitive. Both capture kinds can then be checked side by side under the same acknowledge writes. Lines 6 to 31 are inactive and are driven high, so the rule that out-of-range lines are ignored is checked against live stimulus. Six active lines are enough to pick lines out in a chosen order and to clear enable bits between vector reads, which checks the priority order.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    SEL_STS  = 3'd0,
    SEL_PEND = 3'd1,
    SEL_EN   = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_SET  = 3'd4,
    SEL_CLR  = 3'd5,
    SEL_VEC  = 3'd6,
    SEL_MST  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic hw_en;   // bit 1
    logic out_en;  // bit 0
  } mst_t;

  function automatic logic [DATA_W-1:0] active_mask(int unsigned n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_ctl_pkg::*;
#(
  parameter int unsigned        NUM_ACTIVE = DATA_W,
  parameter logic [DATA_W-1:0]  EDGE_MASK  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] irq_i,
  input  logic              hw_en_i,
  input  logic [DATA_W-1:0] ack_i,
  output logic [DATA_W-1:0] sts_o
);
  localparam logic [DATA_W-1:0] ACT = active_mask(NUM_ACTIVE);

  logic [DATA_W-1:0] prev_q, sts_q, raw_set, set_vec;

  always_comb begin
    raw_set = (irq_i & ~prev_q & EDGE_MASK) | (irq_i & ~EDGE_MASK);
    set_vec = raw_set & ACT & {DATA_W{hw_en_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= irq_i;
      // capture wins over acknowledge in the same cycle
      sts_q  <= (sts_q & ~ack_i) | set_vec;
    end
  end

  assign sts_o = sts_q;

  for (genvar i = 0; i < int'(NUM_ACTIVE) && i < int'(DATA_W); i++) begin : g_chk
    assert_hw_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_q[i]) |-> $past(hw_en_i));
    if (EDGE_MASK[i]) begin : g_edge
      assert_edge_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_q[i]) |-> ($past(irq_i[i]) && !$past(prev_q[i])));
    end else begin : g_level
      assert_level_recap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_en_i && irq_i[i]) |=> sts_q[i]);
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_ctl_pkg::*;
(
  input  logic [DATA_W-1:0] pend_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // descending scan: the last hit is the lowest index
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    assert_vec_pick_R8: assert (!found_o || pend_i[idx_o]);
    assert_vec_none_R8: assert (found_o || pend_i == '0);
  end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int unsigned        NUM_ACTIVE = 32,
  parameter logic [DATA_W-1:0]  EDGE_MASK  = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] en_q, sts, pend, ack, vec, rdata_q, rd_mux;
  mst_t              mst_q;
  logic              found;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        addr_lo;

  assign sel     = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign addr_lo = addr_i[1:0];
  assign ack     = (we_i && sel == SEL_ACK) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      mst_q <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_EN:  en_q  <= wdata_i;
        SEL_SET: en_q  <= en_q | wdata_i;
        SEL_CLR: en_q  <= en_q & ~wdata_i;
        SEL_MST: mst_q <= mst_t'(wdata_i[1:0]);
        default: ;
      endcase
    end
  end

  irq_capture #(
    .NUM_ACTIVE(NUM_ACTIVE),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .hw_en_i(mst_q.hw_en),
    .ack_i  (ack),
    .sts_o  (sts)
  );

  assign pend = sts & en_q;

  irq_prio_enc u_enc (
    .pend_i (pend),
    .found_o(found),
    .idx_o  (idx)
  );

  assign vec   = found ? DATA_W'(idx) : '1;
  assign irq_o = found & mst_q.out_en & mst_q.hw_en;

  always_comb begin
    unique case (sel)
      SEL_STS:  rd_mux = sts;
      SEL_PEND: rd_mux = pend;
      SEL_EN:   rd_mux = en_q;
      SEL_VEC:  rd_mux = vec;
      SEL_MST:  rd_mux = {{(DATA_W-2){1'b0}}, mst_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (addr_lo == 2'b00) ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;

  assert_set_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  assert_clr_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_CLR) |=> ((en_q & $past(wdata_i)) == '0));
  assert_req_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec != '1));
endmodule

// File: tb/tb_irq_ctl_top.sv
module tb_irq_ctl_top;
  localparam logic [4:0] A_STS = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                         A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MST = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0, cap_q = 1'b0;

  always #5 clk = ~clk;

  irq_ctl_top #(.NUM_ACTIVE(6), .EDGE_MASK(32'h0000_000A)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  // driver: present address and queue the expected value
  task automatic rd(logic [4:0] a, logic [31:0] e, string tag);
    addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    tick();
    rd_req = 1'b0;
  endtask

  // monitor: compare one cycle after the address was presented
  always @(posedge clk) cap_q <= rd_req;
  always @(negedge clk) begin
    if (cap_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    rd(A_STS, 32'h0, "R1 status");
    rd(A_EN,  32'h0, "R1 enable");
    rd(A_MST, 32'h0, "R1 master");
    rd(A_VEC, 32'hFFFF_FFFF, "R1 vector idle");

    // R2 full enable write
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, 32'hA5A5_0000, "R2 enable readback");
    wr(A_EN, 32'h0000_003F);
    rd(A_EN, 32'h0000_003F, "R2 enable readback 2");
    // R3 set/clear aliases
    wr(A_CLR, 32'h05);
    rd(A_EN, 32'h3A, "R3 clear alias");
    wr(A_SET, 32'h01);
    rd(A_EN, 32'h3B, "R3 set alias");

    // R10 no capture while hw bit clear
    irq[0] = 1'b1; tick();
    irq[1] = 1'b1; tick();
    rd(A_STS, 32'h0, "R10 no capture");
    irq[1:0] = 2'b00; tick();
    wr(A_MST, 32'h3);
    rd(A_MST, 32'h3, "R9 master readback");

    // R4 edge capture
    irq[1] = 1'b1; tick();
    check("R9 irq_o on edge", {31'b0, irq_o}, 32'h1);
    irq[1] = 1'b0;
    rd(A_STS, 32'h2, "R4 edge held after fall");
    rd(A_VEC, 32'h1, "R8 vector line1");
    rd(A_PEND, 32'h2, "R7 pending");
    irq[3] = 1'b1; tick();
    wr(A_ACK, 32'h8);
    rd(A_STS, 32'h2, "R4 held-high edge not recaptured");
    irq[3] = 1'b0;

    // R5 level capture; line 2 disabled
    irq[2] = 1'b1; tick();
    rd(A_STS, 32'h6, "R5 level captured");
    rd(A_PEND, 32'h2, "R7 disabled line masked");
    wr(A_ACK, 32'h4);
    rd(A_STS, 32'h6, "R5 ack while high recaptured");
    irq[2] = 1'b0; tick();
    wr(A_ACK, 32'h4);
    rd(A_STS, 32'h2, "R5 ack after drop clears");

    // R8 priority
    irq[5:4] = 2'b11; tick();
    rd(A_STS, 32'h32, "R5 lines 4,5");
    rd(A_VEC, 32'h1, "R8 lowest wins");
    wr(A_ACK, 32'h2);
    rd(A_VEC, 32'h4, "R8 next line 4");
    wr(A_CLR, 32'h10);
    rd(A_VEC, 32'h5, "R8 line 5 after mask");
    irq[5:4] = 2'b00; tick();
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STS, 32'h0, "R6 ack all");
    rd(A_VEC, 32'hFFFF_FFFF, "R8 idle again");
    check("R9 irq_o idle", {31'b0, irq_o}, 32'h0);
    wr(A_SET, 32'h10);

    // R9 master gating
    irq[0] = 1'b1; tick();
    check("R9 irq_o full enable", {31'b0, irq_o}, 32'h1);
    wr(A_MST, 32'h1);
    check("R9 irq_o out only", {31'b0, irq_o}, 32'h0);
    wr(A_MST, 32'h2);
    check("R9 irq_o hw only", {31'b0, irq_o}, 32'h0);
    wr(A_MST, 32'h3);
    check("R9 irq_o restored", {31'b0, irq_o}, 32'h1);
    irq[0] = 1'b0; tick();
    wr(A_ACK, 32'h1);
    check("R6 irq_o after ack", {31'b0, irq_o}, 32'h0);

    // R11 inactive lines
    irq[31:6] = '1; tick(); tick();
    rd(A_STS, 32'h0, "R11 inactive lines");
    check("R11 irq_o", {31'b0, irq_o}, 32'h0);
    rd(A_VEC, 32'hFFFF_FFFF, "R11 vector idle");
    irq[31:6] = '0; tick();

    // R6 zero bits untouched
    irq[0] = 1'b1; tick();
    irq[0] = 1'b0; tick();
    wr(A_ACK, 32'h2);
    rd(A_STS, 32'h1, "R6 zero bits keep");
    wr(A_ACK, 32'h1);
    rd(A_STS, 32'h0, "R6 one bit clears");

    tick(); tick();
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule